// File: doc/BRIEF.md
# Predicated Vector Element Issue Compactor

This block sits in the issue stage of a scalar core and expands one vector-style operation into a sequence of per-element issue slots for an ALU that is `LANES` lanes wide. A start strobe captures a vector length, a predicate mask and a mode bit. From the following cycle the block presents up to `LANES` lane slots per cycle. Each slot carries a valid flag, the element index and a flag that marks a zero write. The scalar ALU sees ordinary element operations, so no new instructions are needed to run the operation in parallel.

The predicate is one bit per element and is held in an integer register of `XLEN` bits, so the vector length cannot exceed `XLEN`. In skip mode, elements whose predicate bit is clear are dropped. The active elements are packed down so that every lane issued does useful work. In zero mode, every element below the vector length is issued in order, and the masked ones are flagged as zero writes. A done pulse marks the last issue cycle. A counter reports how many issue cycles the operation used.

Top module: `vec_issue_compactor`

## Requirements
- R1: After reset, `busy`, `done`, every bit of `laneValid` and `laneZero`, and `cycleCount` are all 0.
- R2: A `start` taken while idle raises `busy` in the next cycle. `busy` stays high up to and including the cycle in which `done` is high, and is low in the cycle after that.
- R3: In skip mode (`zeroMode`=0), only elements whose `predMask` bit is 1 are issued. Bit i of `predMask` belongs to element i, and 1 means active. The indices are issued in ascending order. Valid lanes are contiguous from lane 0, and lane 0 carries the lowest remaining index. Lane k's index is `laneIdx[k*IDXW +: IDXW]`.
- R4: In skip mode, an operation with P active elements uses ceil(P/LANES) issue cycles and fills every lane except possibly in its last cycle. For example, eight elements with six active issue four and then two on a 4-lane ALU.
- R5: In zero mode (`zeroMode`=1), every index from 0 to VL-1 is issued in ascending order, LANES per cycle, over ceil(VL/LANES) cycles. `laneZero` is 1 exactly on the lanes whose element has a predicate bit of 0.
- R6: `done` is high for one cycle, in the final issue cycle. Once the operation has finished, `cycleCount` holds the number of cycles in which at least one lane was issued.
- R7: If VL is 0, or if skip mode is selected and no element below VL is active, `done` is high in the cycle after `start`, no lane is issued, and `cycleCount` is 0.
- R8: Predicate bits at positions VL and above have no effect on which elements are issued or flagged.
- R9: A `start` that arrives while `busy` is high is ignored. The operation in progress, its issue sequence and its cycle count are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe; taken only while idle |
| vecLen | input | VLW | Vector length (element count) |
| predMask | input | XLEN | Predicate mask, bit i for element i, 1 = active |
| zeroMode | input | 1 | 1 = issue masked elements as zero writes, 0 = skip them |
| busy | output | 1 | Operation in progress |
| done | output | 1 | High in the final issue cycle |
| laneValid | output | LANES | Per-lane issue valid |
| laneIdx | output | LANES*IDXW | Per-lane element index, lane k at bits k*IDXW upward |
| laneZero | output | LANES | Per-lane zero-write flag |
| cycleCount | output | VLW | Issue cycles used by the current or last operation |

## Verification
Every cycle, the assertions check the lane shape: valid lanes sit contiguous from lane 0, indices rise across lanes, no lane is issued while idle, and zero flags appear only in zero mode. They also check the busy/done handshake and that `busy` rises only after a `start`. Which indices are issued, the zero flag of each one, the issue-cycle totals for skip and zero mode, the empty cases, the masking of predicate bits at or above VL, and the rejection of a second start can only be shown by the bench. It runs a behavioural queue model against the outputs on every cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef struct packed {
    logic load;  // capture a new operation
    logic step;  // issue one group of lanes this cycle
  } issueCtrl_t;
endpackage

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  parameter int VLW   = $clog2(XLEN + 1),
  parameter int IDXW  = $clog2(XLEN)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  issueCtrl_t            ctl,
  input  logic [VLW-1:0]        vecLen,
  input  logic [XLEN-1:0]       predMask,
  input  logic                  zeroMode,
  output logic [LANES-1:0]      laneValid,
  output logic [LANES*IDXW-1:0] laneIdx,
  output logic [LANES-1:0]      laneZero,
  output logic                  lastIssue,
  output logic                  anyIssue
);

  logic [XLEN-1:0] pendR;
  logic [XLEN-1:0] zeroR;
  logic            modeR;
  logic [XLEN-1:0] vlMask;
  logic [XLEN-1:0] remChain [LANES+1];

  function automatic logic [IDXW-1:0] lowestSet(input logic [XLEN-1:0] v);
    logic [IDXW-1:0] r;
    r = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (v[i]) r = IDXW'(i);
    end
    return r;
  endfunction

  always_comb begin
    for (int i = 0; i < XLEN; i++) begin
      vlMask[i] = (VLW'(i) < vecLen);
    end
  end

  assign remChain[0] = pendR;

  generate
    for (genvar k = 0; k < LANES; k++) begin : gLane
      logic [IDXW-1:0] pick;
      always_comb pick = lowestSet(remChain[k]);
      assign remChain[k+1]              = remChain[k] & (remChain[k] - 1'b1);
      assign laneValid[k]               = ctl.step && (remChain[k] != '0);
      assign laneIdx[k*IDXW +: IDXW]    = laneValid[k] ? pick : '0;
      assign laneZero[k]                = laneValid[k] && zeroR[pick];
    end
  endgenerate

  assign lastIssue = (remChain[LANES] == '0);
  assign anyIssue  = ctl.step && (pendR != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendR <= '0;
      zeroR <= '0;
      modeR <= 1'b0;
    end else if (ctl.load) begin
      pendR <= zeroMode ? vlMask : (predMask & vlMask);
      zeroR <= ~predMask & vlMask;
      modeR <= zeroMode;
    end else if (ctl.step) begin
      pendR <= remChain[LANES];
    end
  end

  generate
    for (genvar k = 1; k < LANES; k++) begin : gChk
      // R3
      lanePrefix_chk: assert property (@(posedge clk) disable iff (!rstN)
        laneValid[k] |-> laneValid[k-1]);
      // R3
      laneOrder_chk: assert property (@(posedge clk) disable iff (!rstN)
        laneValid[k] |-> (laneIdx[k*IDXW +: IDXW] > laneIdx[(k-1)*IDXW +: IDXW]));
    end
  endgenerate

  // R2
  idleNoIssue_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.step |-> (laneValid == '0));

  // R3
  zeroOnlyInZeroMode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (laneZero != '0) |-> modeR);

endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
#(
  parameter int VLW = 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic           lastIssue,
  input  logic           anyIssue,
  output issueCtrl_t     ctl,
  output logic           busy,
  output logic           done,
  output logic [VLW-1:0] cycleCount
);

  logic           busyR;
  logic [VLW-1:0] countR;

  assign ctl.load   = start && !busyR;
  assign ctl.step   = busyR;
  assign busy       = busyR;
  assign done       = busyR && lastIssue;
  assign cycleCount = countR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyR  <= 1'b0;
      countR <= '0;
    end else begin
      if (ctl.load) begin
        busyR  <= 1'b1;
        countR <= '0;
      end else begin
        if (done) busyR <= 1'b0;
        if (ctl.step && anyIssue) countR <= countR + 1'b1;
      end
    end
  end

  // R2
  doneInBusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R2
  doneEndsBusy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R2
  busyHeld_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R9
  busyNeedsStart_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

endmodule

// File: rtl/vec_issue_compactor.sv
module vec_issue_compactor
  import vic_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int LANES = 4,
  localparam int VLW  = $clog2(XLEN + 1),
  localparam int IDXW = $clog2(XLEN)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic [VLW-1:0]        vecLen,
  input  logic [XLEN-1:0]       predMask,
  input  logic                  zeroMode,
  output logic                  busy,
  output logic                  done,
  output logic [LANES-1:0]      laneValid,
  output logic [LANES*IDXW-1:0] laneIdx,
  output logic [LANES-1:0]      laneZero,
  output logic [VLW-1:0]        cycleCount
);

  issueCtrl_t ctl;
  logic       lastIssue;
  logic       anyIssue;

  vic_control #(.VLW(VLW)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .lastIssue  (lastIssue),
    .anyIssue   (anyIssue),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done),
    .cycleCount (cycleCount)
  );

  vic_datapath #(.XLEN(XLEN), .LANES(LANES), .VLW(VLW), .IDXW(IDXW)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .vecLen    (vecLen),
    .predMask  (predMask),
    .zeroMode  (zeroMode),
    .laneValid (laneValid),
    .laneIdx   (laneIdx),
    .laneZero  (laneZero),
    .lastIssue (lastIssue),
    .anyIssue  (anyIssue)
  );

endmodule

// File: tb/vec_issue_compactor_tb_top.sv
module vec_issue_compactor_tb_top;
  localparam int XLEN  = 32;
  localparam int LANES = 4;
  localparam int VLW   = $clog2(XLEN + 1);
  localparam int IDXW  = $clog2(XLEN);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [VLW-1:0] vecLen = '0;
  logic [XLEN-1:0] predMask = '0;
  logic zeroMode = 1'b0;
  logic busy, done;
  logic [LANES-1:0] laneValid, laneZero;
  logic [LANES*IDXW-1:0] laneIdx;
  logic [VLW-1:0] cycleCount;

  always #10 clk = ~clk;

  vec_issue_compactor #(.XLEN(XLEN), .LANES(LANES)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .vecLen(vecLen), .predMask(predMask),
    .zeroMode(zeroMode), .busy(busy), .done(done), .laneValid(laneValid),
    .laneIdx(laneIdx), .laneZero(laneZero), .cycleCount(cycleCount)
  );

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit finished = 0;

  // behavioural model: queue of pending elements, entry = index*2 + zeroFlag
  bit mBusy = 0;
  int mQ[$];
  int mCount = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", curReq, what, act, exp);
    end
  endtask

  task automatic tick(input logic st, input int vl, input logic [XLEN-1:0] pm, input logic zm);
    int n;
    bit expDone;
    @(negedge clk);
    n = mBusy ? ((mQ.size() < LANES) ? mQ.size() : LANES) : 0;
    expDone = mBusy && (mQ.size() <= LANES);
    chk(busy == mBusy, "busy", int'(busy), int'(mBusy));
    chk(done == expDone, "done", int'(done), int'(expDone));
    chk(int'(cycleCount) == mCount, "cycleCount", int'(cycleCount), mCount);
    for (int k = 0; k < LANES; k++) begin
      chk(laneValid[k] == (k < n), $sformatf("laneValid[%0d]", k), int'(laneValid[k]), int'(k < n));
      if (k < n && laneValid[k]) begin
        chk(int'(laneIdx[k*IDXW +: IDXW]) == (mQ[k] >> 1), $sformatf("laneIdx[%0d]", k),
            int'(laneIdx[k*IDXW +: IDXW]), mQ[k] >> 1);
        chk(int'(laneZero[k]) == (mQ[k] & 1), $sformatf("laneZero[%0d]", k),
            int'(laneZero[k]), mQ[k] & 1);
      end
    end
    // advance model across the coming edge
    if (rstN) begin
      if (mBusy) begin
        if (n > 0) mCount++;
        for (int k = 0; k < n; k++) void'(mQ.pop_front());
        if (expDone) mBusy = 0;
      end else if (st) begin
        mQ.delete();
        mCount = 0;
        mBusy = 1;
        for (int i = 0; i < vl && i < XLEN; i++) begin
          if (zm) mQ.push_back(i * 2 + (pm[i] ? 0 : 1));
          else if (pm[i]) mQ.push_back(i * 2);
        end
      end
    end
    start    = st;
    vecLen   = VLW'(vl);
    predMask = pm;
    zeroMode = zm;
  endtask

  task automatic runOp(input int vl, input logic [XLEN-1:0] pm, input logic zm,
                       input int expCycles, input string tag);
    curReq = tag;
    tick(1'b1, vl, pm, zm);
    while (mBusy) tick(1'b0, 0, '0, 1'b0);
    tick(1'b0, 0, '0, 1'b0);
    chk(int'(cycleCount) == expCycles, "total issue cycles", int'(cycleCount), expCycles);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [XLEN-1:0] lfsr;
    // R1: reset state
    curReq = "R1";
    tick(1'b0, 0, '0, 1'b0);
    tick(1'b0, 0, '0, 1'b0);
    rstN = 1'b1;
    tick(1'b0, 0, '0, 1'b0);

    // R3 R4: six of eight active, skip mode -> 4 then 2
    runOp(8, 32'h0000_00B7, 1'b0, 2, "R4");
    runOp(8, 32'h0000_00B7, 1'b0, 2, "R3");
    // R5: zero mode, same mask
    runOp(8, 32'h0000_00B7, 1'b1, 2, "R5");
    runOp(7, 32'h0000_0055, 1'b1, 2, "R5");
    // R7: empty cases
    runOp(0, 32'hFFFF_FFFF, 1'b0, 0, "R7");
    runOp(0, 32'hFFFF_FFFF, 1'b1, 0, "R7");
    runOp(10, 32'hFFFF_FC00, 1'b0, 0, "R7");
    // R8: bits at or above VL ignored
    runOp(5, 32'hFFFF_FFE5, 1'b0, 1, "R8");
    runOp(5, 32'hFFFF_FFE5, 1'b1, 2, "R8");
    // R6: full length, all active
    runOp(32, 32'hFFFF_FFFF, 1'b0, 8, "R6");
    runOp(1, 32'h0000_0001, 1'b0, 1, "R6");

    // R9: second start during busy is ignored
    curReq = "R9";
    tick(1'b1, 32, 32'hFFFF_FFFF, 1'b0);
    tick(1'b0, 0, '0, 1'b0);
    tick(1'b1, 3, 32'h0000_0001, 1'b1);
    tick(1'b1, 2, 32'h0000_0002, 1'b0);
    while (mBusy) tick(1'b0, 0, '0, 1'b0);
    tick(1'b0, 0, '0, 1'b0);
    chk(int'(cycleCount) == 8, "total issue cycles", int'(cycleCount), 8);

    // R2 R3 R5: pseudo-random masks and lengths, both modes
    lfsr = 32'h1ACE_B00C;
    for (int t = 0; t < 40; t++) begin
      int vl;
      int pop;
      int exp;
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      vl = int'(lfsr[4:0]) + (t % 2);
      pop = 0;
      for (int i = 0; i < vl; i++) if (lfsr[i]) pop++;
      if (t % 3 == 0) begin
        exp = (vl + LANES - 1) / LANES;
        runOp(vl, lfsr, 1'b1, exp, "R5");
      end else begin
        exp = (pop + LANES - 1) / LANES;
        runOp(vl, lfsr, 1'b0, exp, (t % 3 == 1) ? "R3" : "R2");
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule